// File: doc/BRIEF.md
# LIN Bus Error and Status Monitor

This block sits next to an existing LIN-style serial engine and watches the single-wire bus from the side. It samples the transmit and receive lines on a bit-time strobe and takes byte-boundary strobes from the engine. From these it keeps a small register of sticky status flags: echo mismatch, stuck bus, slave response timeout, receive overrun, receiver busy, frame done and wake-up seen. Whenever a fault means that the frame in progress can no longer be trusted, the block also pulses a reset request to the frame state machine.

The echo comparison has two modes. In the bit-wise mode every transmitted bit is compared with its read-back as it happens. In the byte-wise mode mismatches are gathered and reported once, when the engine signals that the byte has been sent and read back in full. The slave timeout is measured in tenths of a bit time, so the limit of 1.4 × (10·N + 44) bit times is handled in integer arithmetic. Software clears each sticky flag by writing 1 to its position. All interfaces are plain strobes and levels: the engine's byte events cannot be held back, so the block has no valid/ready handshake and accepts every event in the cycle it is presented.

Top module: `lin_err_monitor`

## Requirements
- R1: After the asynchronous active-low reset, `flags` reads 0 and `fsm_rst` is low.
- R2: Flag positions in `flags`: bit 0 echo/bit error, bit 1 stuck-bus error, bit 2 slave timeout, bit 3 receive overrun, bit 4 receiver busy, bit 5 frame done, bit 6 wake-up seen. A flag is visible in the cycle after the event that sets it.
- R3: With `fast_chk`=1, a `bit_tick` between `byte_tx_start` and `byte_tx_done` on which `tx_bit` differs from `rx_bit` sets bit 0 at once.
- R4: With `fast_chk`=0, a mismatch inside a byte sets bit 0 only on `byte_tx_done`; before then bit 0 stays clear, and a byte without mismatches sets nothing.
- R5: A `rx_byte_done` with `rx_expected`=0 sets bit 0 unless `rx_is_wake`=1.
- R6: Each bit-0 set event pulses `fsm_rst` high for one cycle, together with the flag, unless `dbg_en`=1.
- R7: After `byte_tx_start`, 31 consecutive `bit_tick` samples of an unchanged `rx_bit` set bit 1 and pulse `fsm_rst`. A change of `rx_bit` restarts the count, and `byte_tx_done` stops it.
- R8: After `frame_start`, if `frame_done` has not arrived by the `bit_tick` on which 10 × ticks ≥ 14 × (10·`ndata` + 44), bit 2 is set and `fsm_rst` pulses. With `ndata`=1 this is the 76th tick.
- R9: `frame_done` sets bit 5 and stops the timeout count.
- R10: A `rx_byte_done` with `rx_expected`=1 while the previous byte is unread sets bit 3. `rd_data` marks the byte as read, and a read in the same cycle as a new byte prevents the overrun.
- R11: `rx_start_low` sets bit 4 and `rx_idle` clears it. Writes have no effect on bit 4.
- R12: `wake_det` sets bit 6 and pulses `fsm_rst`.
- R13: `wr_en` with a 1 in `wr_data` clears that flag, and 0s leave flags unchanged. A hardware set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| tx_bit | input | 1 | Level driven onto the bus |
| rx_bit | input | 1 | Level read back from the bus |
| fast_chk | input | 1 | 1: bit-wise echo check, 0: byte-wise |
| dbg_en | input | 1 | Suppresses reset requests caused by bit errors |
| byte_tx_start | input | 1 | Engine begins sending a byte |
| byte_tx_done | input | 1 | Sent byte fully read back |
| rx_byte_done | input | 1 | Engine received a byte |
| rx_expected | input | 1 | Received byte belongs to a response frame |
| rx_is_wake | input | 1 | Received byte is a wake-up pattern |
| rx_start_low | input | 1 | Low seen in the first sub-slot of the start-bit search |
| rx_idle | input | 1 | Idle character detected |
| wake_det | input | 1 | Wake-up pulse detected |
| frame_start | input | 1 | Frame begins; timeout count restarts |
| frame_done | input | 1 | Frame completed |
| ndata | input | 4 | Data byte count of the frame |
| rd_data | input | 1 | Software read of the received data byte |
| wr_en | input | 1 | Write strobe to the flag register |
| wr_data | input | 7 | Write-one-to-clear mask |
| flags | output | 7 | Sticky flag register |
| fsm_rst | output | 1 | One-cycle reset request to the frame state machine |

## Verification
The hardest state to reach from the ports is the slave timeout at its exact boundary. It only fires after dozens of bit ticks with a frame open and no completion, and any stray byte event would disturb the result. The bench opens a frame with `ndata`=1, issues exactly 75 ticks and checks that the flag is still clear, then issues the 76th tick and checks that the flag and the reset request appear. The stuck-bus window is handled the same way: 30 ticks, one tick short of the limit, then a level change that must restart the count.

// File: rtl/lin_mon_pkg.sv
package lin_mon_pkg;
  localparam int FLAG_W   = 7;
  localparam int F_BITERR = 0;
  localparam int F_BUSERR = 1;
  localparam int F_TMOUT  = 2;
  localparam int F_OVRUN  = 3;
  localparam int F_RXBUSY = 4;
  localparam int F_DONE   = 5;
  localparam int F_WAKE   = 6;
  // flags cleared by write-one; receiver busy follows the line state instead
  localparam logic [FLAG_W-1:0] W1C_MASK = 7'b110_1111;
  localparam logic [FLAG_W-1:0] RST_MASK = 7'b100_0111;
endpackage

// File: rtl/lin_echo_chk.sv
module lin_echo_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_bit,
  input  logic rx_bit,
  input  logic fast_chk,
  input  logic byte_tx_start,
  input  logic byte_tx_done,
  output logic berr_set
);
  logic busy, acc, mism;

  assign mism = bit_tick & busy & (tx_bit ^ rx_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      acc  <= 1'b0;
    end else begin
      if (byte_tx_start) begin
        busy <= 1'b1;
        acc  <= 1'b0;
      end else if (byte_tx_done) begin
        busy <= 1'b0;
        acc  <= 1'b0;
      end else if (mism) begin
        acc  <= 1'b1;
      end
    end
  end

  assign berr_set = fast_chk ? mism : (byte_tx_done & busy & (acc | mism));
endmodule

// File: rtl/lin_stuck_det.sv
module lin_stuck_det #(
  parameter int LIMIT = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic byte_tx_start,
  input  logic byte_tx_done,
  output logic stuck_set
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          armed, prev;
  logic [CW-1:0] run;
  logic          same;

  assign same      = (rx_bit == prev);
  assign stuck_set = armed & bit_tick & same & (run == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      prev  <= 1'b0;
      run   <= '0;
    end else if (byte_tx_start) begin
      armed <= 1'b1;
      prev  <= rx_bit;
      run   <= '0;
    end else if (byte_tx_done || stuck_set) begin
      armed <= 1'b0;
      run   <= '0;
    end else if (armed && bit_tick) begin
      if (!same) begin
        prev <= rx_bit;
        run  <= '0;
      end else begin
        run  <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_frame_timer.sv
module lin_frame_timer #(
  parameter int ND_W  = 4,
  parameter int CNT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            frame_start,
  input  logic            frame_done,
  input  logic [ND_W-1:0] ndata,
  output logic            tmo_set
);
  logic             active;
  logic [CNT_W-1:0] tenths, nxt, limit;

  // limit in tenths of a bit time: 14 * (10*N + 44)
  assign limit = CNT_W'(14) * (CNT_W'(10) * CNT_W'(ndata) + CNT_W'(44));
  assign nxt   = tenths + CNT_W'(10);
  assign tmo_set = active & bit_tick & ~frame_done & ~frame_start & (nxt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tenths <= '0;
    end else if (frame_start) begin
      active <= 1'b1;
      tenths <= '0;
    end else if (frame_done || tmo_set) begin
      active <= 1'b0;
    end else if (active && bit_tick) begin
      tenths <= nxt;
    end
  end
endmodule

// File: rtl/lin_err_monitor.sv
module lin_err_monitor
  import lin_mon_pkg::*;
#(
  parameter int STUCK_LIMIT = 31,
  parameter int ND_W        = 4,
  parameter int CNT_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_bit,
  input  logic              rx_bit,
  input  logic              fast_chk,
  input  logic              dbg_en,
  input  logic              byte_tx_start,
  input  logic              byte_tx_done,
  input  logic              rx_byte_done,
  input  logic              rx_expected,
  input  logic              rx_is_wake,
  input  logic              rx_start_low,
  input  logic              rx_idle,
  input  logic              wake_det,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic [ND_W-1:0]   ndata,
  input  logic              rd_data,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags,
  output logic              fsm_rst
);
  logic echo_err, stuck_err, tmo_err, stray_err, ovr_err;
  logic unread;
  logic [FLAG_W-1:0] set_v, clr_v;

  lin_echo_chk u_echo (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_bit(tx_bit),
    .rx_bit(rx_bit), .fast_chk(fast_chk), .byte_tx_start(byte_tx_start),
    .byte_tx_done(byte_tx_done), .berr_set(echo_err)
  );

  lin_stuck_det #(.LIMIT(STUCK_LIMIT)) u_stuck (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .byte_tx_start(byte_tx_start), .byte_tx_done(byte_tx_done),
    .stuck_set(stuck_err)
  );

  lin_frame_timer #(.ND_W(ND_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
    .frame_done(frame_done), .ndata(ndata), .tmo_set(tmo_err)
  );

  assign stray_err = rx_byte_done & ~rx_expected & ~rx_is_wake;
  assign ovr_err   = rx_byte_done & rx_expected & unread & ~rd_data;

  always_comb begin
    set_v           = '0;
    set_v[F_BITERR] = echo_err | stray_err;
    set_v[F_BUSERR] = stuck_err;
    set_v[F_TMOUT]  = tmo_err;
    set_v[F_OVRUN]  = ovr_err;
    set_v[F_DONE]   = frame_done;
    set_v[F_WAKE]   = wake_det;
    clr_v           = wr_en ? (wr_data & W1C_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      fsm_rst <= 1'b0;
      unread  <= 1'b0;
    end else begin
      flags <= ((flags & ~clr_v) | set_v) & W1C_MASK;
      if (rx_start_low)      flags[F_RXBUSY] <= 1'b1;
      else if (rx_idle)      flags[F_RXBUSY] <= 1'b0;
      else                   flags[F_RXBUSY] <= flags[F_RXBUSY];
      fsm_rst <= (set_v[F_BITERR] & ~dbg_en) | stuck_err | tmo_err | wake_det;
      if (rx_byte_done && rx_expected) unread <= 1'b1;
      else if (rd_data)                unread <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_err_monitor_chk.sv
module lin_err_monitor_chk
  import lin_mon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_en,
  input logic              rx_byte_done,
  input logic              rx_expected,
  input logic              rx_start_low,
  input logic              rx_idle,
  input logic              frame_done,
  input logic              wr_en,
  input logic [FLAG_W-1:0] wr_data,
  input logic [FLAG_W-1:0] flags,
  input logic              fsm_rst
);
  // R13: a sticky error flag only drops after a write of 1 to it
  p_w1c_biterr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_BITERR]) |-> $past(wr_en && wr_data[F_BITERR]));
  p_w1c_wake_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_WAKE]) |-> $past(wr_en && wr_data[F_WAKE]));

  // R6/R7/R8/R12: every reset request comes with a fault flag standing
  p_rst_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_rst |-> ((flags & RST_MASK) != '0));

  // R6: with debug on, a reset request has a cause other than the bit error
  p_dbg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_rst && $past(dbg_en)) |-> (flags[F_BUSERR] || flags[F_TMOUT] || flags[F_WAKE]));

  // R10: overrun rises only after an expected byte arrived
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_OVRUN]) |-> $past(rx_byte_done && rx_expected));

  // R11: idle without a new start low clears receiver busy
  p_rxbusy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_idle) && !$past(rx_start_low)) |-> !flags[F_RXBUSY]);

  // R9: frame done flag rises only on a completion strobe
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_DONE]) |-> $past(frame_done));
endmodule

bind lin_err_monitor lin_err_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .rx_byte_done(rx_byte_done),
  .rx_expected(rx_expected), .rx_start_low(rx_start_low), .rx_idle(rx_idle),
  .frame_done(frame_done), .wr_en(wr_en), .wr_data(wr_data),
  .flags(flags), .fsm_rst(fsm_rst)
);

// File: tb/lin_err_monitor_tb_top.sv
`timescale 1ns/1ps
module lin_err_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, tx_bit = 1, rx_bit = 1, fast_chk = 0, dbg_en = 0;
  logic byte_tx_start = 0, byte_tx_done = 0, rx_byte_done = 0, rx_expected = 0;
  logic rx_is_wake = 0, rx_start_low = 0, rx_idle = 0, wake_det = 0;
  logic frame_start = 0, frame_done = 0, rd_data = 0, wr_en = 0;
  logic [3:0] ndata = 4'd1;
  logic [6:0] wr_data = '0;
  logic [6:0] flags;
  logic       fsm_rst;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  lin_err_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .fast_chk(fast_chk), .dbg_en(dbg_en), .byte_tx_start(byte_tx_start),
    .byte_tx_done(byte_tx_done), .rx_byte_done(rx_byte_done), .rx_expected(rx_expected),
    .rx_is_wake(rx_is_wake), .rx_start_low(rx_start_low), .rx_idle(rx_idle),
    .wake_det(wake_det), .frame_start(frame_start), .frame_done(frame_done),
    .ndata(ndata), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
    .flags(flags), .fsm_rst(fsm_rst)
  );

  typedef struct packed {
    logic       fast;
    logic [7:0] tx;
    logic [7:0] rx;
    logic       exp_err;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 8'hA5, 8'hA5, 1'b0},
    '{1'b1, 8'h3C, 8'h3D, 1'b1},
    '{1'b0, 8'hFF, 8'hFF, 1'b0},
    '{1'b0, 8'h00, 8'h80, 1'b1},
    '{1'b0, 8'h55, 8'h54, 1'b1},
    '{1'b1, 8'h0F, 8'h0F, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick(logic t, logic r);
    bit_tick = 1; tx_bit = t; rx_bit = r;
    cyc();
    bit_tick = 0;
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 7'h7F; cyc(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic saw;
    repeat (2) cyc();
    chk("R1 flags", {25'd0, flags}, 0);
    chk("R1 fsm_rst", {31'd0, fsm_rst}, 0);
    rst_n = 1; cyc();

    // R3/R4 echo vectors
    foreach (VEC[i]) begin
      clear_all();
      fast_chk = VEC[i].fast;
      byte_tx_start = 1; cyc(); byte_tx_start = 0;
      for (int b = 0; b < 8; b++) tick(VEC[i].tx[b], VEC[i].rx[b]);
      if (!VEC[i].fast) chk("R4 no flag before byte end", {31'd0, flags[0]}, 0);
      byte_tx_done = 1; cyc(); byte_tx_done = 0;
      chk(VEC[i].fast ? "R3 bitwise echo" : "R4 bytewise echo", {31'd0, flags[0]}, {31'd0, VEC[i].exp_err});
    end

    // R3 immediate flag and R6 reset pulse with it
    clear_all(); fast_chk = 1; dbg_en = 0;
    byte_tx_start = 1; cyc(); byte_tx_start = 0;
    tick(1, 0);
    chk("R3 flag right after tick", {31'd0, flags[0]}, 1);
    chk("R6 fsm_rst pulse", {31'd0, fsm_rst}, 1);
    cyc();
    chk("R6 pulse is one cycle", {31'd0, fsm_rst}, 0);
    byte_tx_done = 1; cyc(); byte_tx_done = 0;

    // R6 debug suppresses the reset request
    clear_all(); dbg_en = 1;
    byte_tx_start = 1; cyc(); byte_tx_start = 0;
    tick(0, 1);
    chk("R6 flag with debug", {31'd0, flags[0]}, 1);
    chk("R6 no fsm_rst with debug", {31'd0, fsm_rst}, 0);
    byte_tx_done = 1; cyc(); byte_tx_done = 0; dbg_en = 0;

    // R5 stray byte vs wake byte
    clear_all();
    rx_byte_done = 1; rx_expected = 0; rx_is_wake = 1; cyc(); rx_byte_done = 0; rx_is_wake = 0;
    chk("R5 wake byte ignored", {31'd0, flags[0]}, 0);
    rx_byte_done = 1; cyc(); rx_byte_done = 0;
    chk("R5 stray byte flags", {31'd0, flags[0]}, 1);

    // R7 stuck bus, 30 then 31
    clear_all(); fast_chk = 1;
    byte_tx_start = 1; tx_bit = 1; rx_bit = 1; cyc(); byte_tx_start = 0;
    for (int k = 0; k < 30; k++) tick(1, 1);
    chk("R7 no error at 30", {31'd0, flags[1]}, 0);
    tick(1, 1);
    chk("R7 error at 31", {31'd0, flags[1]}, 1);
    chk("R7 fsm_rst", {31'd0, fsm_rst}, 1);
    byte_tx_done = 1; cyc(); byte_tx_done = 0;

    // R7 a change restarts the count
    clear_all();
    byte_tx_start = 1; cyc(); byte_tx_start = 0;
    for (int k = 0; k < 20; k++) tick(1, 1);
    tick(0, 0);
    for (int k = 0; k < 30; k++) tick(0, 0);
    chk("R7 restart after change", {31'd0, flags[1]}, 0);
    tick(0, 0);
    chk("R7 error after restart", {31'd0, flags[1]}, 1);
    byte_tx_done = 1; cyc(); byte_tx_done = 0;

    // R8 timeout boundary, ndata=1 -> tick 76
    clear_all(); ndata = 4'd1;
    frame_start = 1; cyc(); frame_start = 0;
    for (int k = 0; k < 75; k++) tick(1, 1);
    chk("R8 no timeout at 75", {31'd0, flags[2]}, 0);
    tick(1, 1);
    chk("R8 timeout at 76", {31'd0, flags[2]}, 1);
    chk("R8 fsm_rst", {31'd0, fsm_rst}, 1);

    // R8 ndata=8 -> 1736 tenths -> tick 174
    clear_all(); ndata = 4'd8;
    frame_start = 1; cyc(); frame_start = 0;
    for (int k = 0; k < 173; k++) tick(1, 1);
    chk("R8 ndata8 no timeout at 173", {31'd0, flags[2]}, 0);
    tick(1, 1);
    chk("R8 ndata8 timeout at 174", {31'd0, flags[2]}, 1);

    // R9 completion stops the count
    clear_all(); ndata = 4'd1;
    frame_start = 1; cyc(); frame_start = 0;
    for (int k = 0; k < 50; k++) tick(1, 1);
    frame_done = 1; cyc(); frame_done = 0;
    chk("R9 done flag", {31'd0, flags[5]}, 1);
    for (int k = 0; k < 40; k++) tick(1, 1);
    chk("R9 no timeout after done", {31'd0, flags[2]}, 0);

    // R10 overrun
    clear_all();
    rx_expected = 1;
    rx_byte_done = 1; cyc(); rx_byte_done = 0;
    chk("R10 first byte no overrun", {31'd0, flags[3]}, 0);
    rx_byte_done = 1; rd_data = 1; cyc(); rx_byte_done = 0; rd_data = 0;
    chk("R10 read same cycle no overrun", {31'd0, flags[3]}, 0);
    rx_byte_done = 1; cyc(); rx_byte_done = 0;
    chk("R10 unread overrun", {31'd0, flags[3]}, 1);
    rd_data = 1; cyc(); rd_data = 0; rx_expected = 0;

    // R11 receiver busy
    rx_start_low = 1; cyc(); rx_start_low = 0;
    chk("R11 busy set", {31'd0, flags[4]}, 1);
    wr_en = 1; wr_data = 7'h10; cyc(); wr_en = 0; wr_data = '0;
    chk("R11 write ignored", {31'd0, flags[4]}, 1);
    rx_idle = 1; cyc(); rx_idle = 0;
    chk("R11 busy cleared by idle", {31'd0, flags[4]}, 0);

    // R12 wake
    clear_all();
    wake_det = 1; cyc(); wake_det = 0;
    chk("R12 wake flag", {31'd0, flags[6]}, 1);
    chk("R12 fsm_rst", {31'd0, fsm_rst}, 1);

    // R13 write zero, write one, set wins
    wr_en = 1; wr_data = 7'h00; cyc(); wr_en = 0;
    chk("R13 zero write keeps", {31'd0, flags[6]}, 1);
    wr_en = 1; wr_data = 7'h40; cyc(); wr_en = 0; wr_data = '0;
    chk("R13 one clears", {31'd0, flags[6]}, 0);
    wr_en = 1; wr_data = 7'h40; wake_det = 1; cyc(); wr_en = 0; wr_data = '0; wake_det = 0;
    chk("R13 set wins", {31'd0, flags[6]}, 1);

    // R2 layout: only wake bit stands now
    chk("R2 flag positions", {25'd0, flags}, 32'h40);

    // R1 reset mid-run
    saw = 0;
    rst_n = 0; cyc();
    chk("R1 async reset flags", {25'd0, flags}, 0);
    rst_n = 1; cyc();
    chk("R1 stays clear", {31'd0, fsm_rst}, {31'd0, saw});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule